// File: doc/BRIEF.md
# Thermally Scaled Refresh Timer

This block paces periodic DRAM refresh. A free-running interval timer counts clock cycles against a nominal refresh period, given as a parameter in cycles. A 2-bit thermal scale code taken from the temperature logic divides that period by one, two or four, so a hot device is refreshed more often. Each expiry of the timer adds one refresh to a small pending counter. The command scheduler drains that counter through a valid/ready handshake.

An emergency input puts the block into self-refresh mode. While it is high, the timer is frozen, pending refreshes are discarded and no refresh is offered. A one-cycle entry request marks the start of this mode and a one-cycle exit request marks its end, so the scheduler can move the device into and out of self-refresh. On exit the timer starts again from zero.

Handshake rules: `ref_valid` is high whenever at least one refresh is pending and the block is not in self-refresh. One refresh is consumed on each rising clock edge where `ref_valid` and `ref_ready` are both high. `ref_ready` has no effect while `ref_valid` is low. The scheduler may hold `ref_ready` low for as long as it needs. Refreshes then build up, up to a fixed maximum.

Top module: `therm_refresh_timer`

## Requirements
- R1: After reset, `ref_valid`, `pend_count`, `pend_ovf`, `sr_enter_req` and `sr_exit_req` are all zero.
- R2: With `scale_code` = 2'b00 held steady, the timer expires once every BASE_CYCLES clock cycles, and each expiry adds one refresh to the pending counter.
- R3: With `scale_code` = 2'b01 the interval is BASE_CYCLES/2. With 2'b10 it is BASE_CYCLES/4. Code 2'b11 gives the same interval as 2'b10.
- R4: A scale change applies from the next timer reload. If the new interval is shorter than the count already elapsed, the timer expires on the very next clock edge. If the new interval is longer, the interval already running completes at its old length.
- R5: `ref_valid` stays high while refreshes are pending, and each valid-and-ready edge lowers `pend_count` by one. `ref_ready` while `ref_valid` is low leaves `pend_count` unchanged.
- R6: `pend_count` saturates at PEND_MAX. An expiry while it is already at PEND_MAX sets `pend_ovf`, which then stays set until reset.
- R7: A rising edge on `hot_stop` produces a single-cycle `sr_enter_req` in the following cycle. A falling edge produces a single-cycle `sr_exit_req` in the following cycle.
- R8: While in self-refresh, `ref_valid` stays low, `pend_count` is cleared to zero, and the timer produces no expiries.
- R9: After self-refresh exit, the first refresh is offered exactly one current interval after the cycle in which `sr_exit_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scale_code | input | 2 | Thermal interval scale: 00 full, 01 half, 10/11 quarter |
| hot_stop | input | 1 | Emergency: high selects self-refresh only |
| ref_valid | output | 1 | A refresh is pending and offered to the scheduler |
| ref_ready | input | 1 | Scheduler accepts one refresh |
| pend_count | output | CW | Number of refreshes not yet accepted |
| pend_ovf | output | 1 | Sticky flag: an expiry was lost at the maximum |
| sr_enter_req | output | 1 | One-cycle request to enter self-refresh |
| sr_exit_req | output | 1 | One-cycle request to exit self-refresh |

## Verification
The assertions assume that `hot_stop` and `ref_ready` are synchronous to `clk` and change only between edges. They also assume that `hot_stop` is low throughout reset, so the first edge seen after reset is a real one. The bench drives every input on the falling edge and keeps `hot_stop` low until reset has been released. It holds each emergency level for many cycles, so every entry and exit pulse can be observed on its own.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {
    SC_FULL    = 2'b00,
    SC_HALF    = 2'b01,
    SC_QUARTER = 2'b10,
    SC_QALT    = 2'b11
  } scale_e;

  // Right-shift applied to the base interval for a scale code.
  function automatic int unsigned scale_shift(logic [1:0] code);
    case (code)
      SC_FULL: return 0;
      SC_HALF: return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/rt_period_sel.sv
module rt_period_sel #(
  parameter int unsigned BASE_CYCLES = 3900,
  parameter int unsigned TW          = 12
) (
  input  logic [1:0]    scale_code,
  output logic [TW-1:0] live_period
);
  logic [TW-1:0] cand [4];

  for (genvar g = 0; g < 4; g++) begin : g_cand
    localparam int unsigned SHIFT = rt_pkg::scale_shift(2'(g));
    assign cand[g] = TW'(BASE_CYCLES >> SHIFT);
  end

  assign live_period = cand[scale_code];
endmodule

// File: rtl/rt_interval_timer.sv
module rt_interval_timer #(
  parameter int unsigned BASE_CYCLES = 3900,
  parameter int unsigned TW          = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [TW-1:0] live_period,
  output logic          tick
);
  logic [TW-1:0] elapsed;
  logic [TW-1:0] active_period;
  logic [TW-1:0] next_elapsed;
  logic [TW-1:0] eff_period;

  assign next_elapsed = elapsed + 1'b1;
  // A shorter new period takes over at once; a longer one waits for reload.
  assign eff_period   = (live_period < active_period) ? live_period : active_period;
  assign tick         = !hold && (next_elapsed >= eff_period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed       <= '0;
      active_period <= TW'(BASE_CYCLES);
    end else if (hold || tick) begin
      elapsed       <= '0;
      active_period <= live_period;
    end else begin
      elapsed       <= next_elapsed;
    end
  end
endmodule

// File: rtl/rt_pending_ctr.sv
module rt_pending_ctr #(
  parameter int unsigned PEND_MAX = 8,
  parameter int unsigned CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          tick,
  input  logic          take,
  output logic [CW-1:0] count,
  output logic          ovf
);
  localparam logic [CW-1:0] MAXV = CW'(PEND_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (flush) begin
      count <= '0;
    end else if (tick && !take) begin
      if (count == MAXV) ovf   <= 1'b1;
      else               count <= count + 1'b1;
    end else if (take && !tick) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/rt_selfref_edge.sv
module rt_selfref_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_stop,
  output logic sr_active,
  output logic enter_req,
  output logic exit_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_active <= 1'b0;
      enter_req <= 1'b0;
      exit_req  <= 1'b0;
    end else begin
      sr_active <= hot_stop;
      enter_req <= hot_stop && !sr_active;
      exit_req  <= !hot_stop && sr_active;
    end
  end
endmodule

// File: rtl/therm_refresh_timer.sv
module therm_refresh_timer #(
  parameter int unsigned BASE_CYCLES = 3900,
  parameter int unsigned PEND_MAX    = 8,
  localparam int unsigned TW         = $clog2(BASE_CYCLES + 1),
  localparam int unsigned CW         = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    scale_code,
  input  logic          hot_stop,
  output logic          ref_valid,
  input  logic          ref_ready,
  output logic [CW-1:0] pend_count,
  output logic          pend_ovf,
  output logic          sr_enter_req,
  output logic          sr_exit_req
);
  logic [TW-1:0] live_period;
  logic          tick;
  logic          sr_active;
  logic          take;

  rt_period_sel #(.BASE_CYCLES(BASE_CYCLES), .TW(TW)) u_sel (
    .scale_code (scale_code),
    .live_period(live_period)
  );

  rt_selfref_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .hot_stop (hot_stop),
    .sr_active(sr_active),
    .enter_req(sr_enter_req),
    .exit_req (sr_exit_req)
  );

  rt_interval_timer #(.BASE_CYCLES(BASE_CYCLES), .TW(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (sr_active),
    .live_period(live_period),
    .tick       (tick)
  );

  assign ref_valid = (pend_count != '0) && !sr_active;
  assign take      = ref_valid && ref_ready;

  rt_pending_ctr #(.PEND_MAX(PEND_MAX), .CW(CW)) u_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(sr_active),
    .tick (tick),
    .take (take),
    .count(pend_count),
    .ovf  (pend_ovf)
  );
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int unsigned PEND_MAX = 8,
  parameter int unsigned CW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hot_stop,
  input logic          ref_valid,
  input logic          ref_ready,
  input logic [CW-1:0] pend_count,
  input logic          pend_ovf,
  input logic          sr_enter_req,
  input logic          sr_exit_req,
  input logic          in_sr,
  input logic          tick
);
  assert_take_decrements_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_ready && !tick) |=> (pend_count == $past(pend_count) - 1'b1));

  assert_valid_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !ref_ready) |=> (ref_valid || in_sr));

  assert_pend_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_count <= CW'(PEND_MAX));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_ovf |=> pend_ovf);

  assert_ovf_at_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_ovf) |-> ($past(pend_count) == CW'(PEND_MAX)));

  assert_quiet_in_sr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr |-> (!ref_valid && !tick));

  assert_enter_follows_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter_req |-> $past(hot_stop));

  assert_exit_follows_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_req |-> !$past(hot_stop));

  assert_enter_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter_req |=> !sr_enter_req);

  assert_pulses_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_enter_req && sr_exit_req));
endmodule

bind therm_refresh_timer rt_checker #(.PEND_MAX(PEND_MAX), .CW(CW)) u_rt_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .hot_stop    (hot_stop),
  .ref_valid   (ref_valid),
  .ref_ready   (ref_ready),
  .pend_count  (pend_count),
  .pend_ovf    (pend_ovf),
  .sr_enter_req(sr_enter_req),
  .sr_exit_req (sr_exit_req),
  .in_sr       (sr_active),
  .tick        (tick)
);

// File: tb/test_therm_refresh_timer.sv
`timescale 1ns/1ps
module test_therm_refresh_timer;
  localparam int BASE = 64;
  localparam int PMAX = 8;
  localparam int CW   = $clog2(PMAX + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    scale_code = 2'b00;
  logic          hot_stop = 1'b0;
  logic          ref_valid;
  logic          ref_ready = 1'b0;
  logic [CW-1:0] pend_count;
  logic          pend_ovf;
  logic          sr_enter_req;
  logic          sr_exit_req;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  therm_refresh_timer #(.BASE_CYCLES(BASE), .PEND_MAX(PMAX)) i_therm_refresh_timer (
    .clk(clk), .rst_n(rst_n), .scale_code(scale_code), .hot_stop(hot_stop),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .pend_count(pend_count),
    .pend_ovf(pend_ovf), .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  // Counts falling edges until ref_valid rises.
  task automatic wait_rise(output int n);
    bit prev = ref_valid;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      n++;
      if (ref_valid && !prev) return;
      prev = ref_valid;
    end
    n = -1;
  endtask

  task automatic t_reset();
    check(!ref_valid, "R1 ref_valid", ref_valid, 0);
    check(pend_count == 0, "R1 pend_count", pend_count, 0);
    check(!pend_ovf && !sr_enter_req && !sr_exit_req, "R1 flags",
          {pend_ovf, sr_enter_req, sr_exit_req}, 0);
  endtask

  task automatic t_full();
    int n;
    ref_ready = 1'b1;
    wait_rise(n);
    wait_rise(n); check(n == BASE, "R2 full interval", n, BASE);
    wait_rise(n); check(n == BASE, "R2 full interval repeat", n, BASE);
  endtask

  task automatic t_scaled(input logic [1:0] code, input int expn, input string req);
    int n;
    scale_code = code;
    wait_rise(n);
    wait_rise(n); check(n == expn, req, n, expn);
  endtask

  task automatic t_change();
    int n;
    // currently period 16; lengthen to full right after a rise
    scale_code = 2'b00;
    wait_rise(n); check(n == BASE/4, "R4 running interval keeps old length", n, BASE/4);
    wait_rise(n); check(n == BASE, "R4 new longer interval", n, BASE);
    for (int i = 0; i < 40; i++) @(negedge clk);
    check(!ref_valid, "R4 no early expiry", ref_valid, 0);
    scale_code = 2'b10;
    @(negedge clk);
    check(ref_valid, "R4 immediate expiry on shortening", ref_valid, 1);
  endtask

  task automatic t_backpressure();
    int guard = 0;
    ref_ready = 1'b0;
    while (pend_count != 2 && guard < 500) begin @(negedge clk); guard++; end
    check(pend_count == 2, "R5 accumulate", pend_count, 2);
    @(negedge clk);
    check(ref_valid && pend_count == 2, "R5 valid held without ready", pend_count, 2);
    ref_ready = 1'b1;
    @(negedge clk);
    ref_ready = 1'b0;
    check(pend_count == 1, "R5 one taken per handshake", pend_count, 1);
  endtask

  task automatic t_saturate();
    int guard = 0;
    while (pend_count != PMAX && guard < 500) begin @(negedge clk); guard++; end
    check(pend_count == PMAX, "R6 reaches max", pend_count, PMAX);
    check(!pend_ovf, "R6 no overflow at max", pend_ovf, 0);
    for (int i = 0; i < 20; i++) @(negedge clk);
    check(pend_ovf, "R6 overflow set", pend_ovf, 1);
    check(pend_count == PMAX, "R6 count saturates", pend_count, PMAX);
    for (int i = 0; i < 5; i++) @(negedge clk);
    check(pend_ovf, "R6 overflow sticky", pend_ovf, 1);
  endtask

  task automatic t_emergency();
    int n;
    int bad = 0;
    scale_code = 2'b01;
    hot_stop = 1'b1;
    @(negedge clk);
    check(sr_enter_req, "R7 entry pulse", sr_enter_req, 1);
    check(!ref_valid, "R8 no request in self-refresh", ref_valid, 0);
    @(negedge clk);
    check(!sr_enter_req, "R7 entry pulse single", sr_enter_req, 0);
    check(pend_count == 0, "R8 pending cleared", pend_count, 0);
    ref_ready = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ref_valid || pend_count != 0 || sr_enter_req || sr_exit_req) bad++;
    end
    check(bad == 0, "R8 quiet for 100 cycles", bad, 0);
    hot_stop = 1'b0;
    @(negedge clk);
    check(sr_exit_req, "R7 exit pulse", sr_exit_req, 1);
    check(pend_count == 0, "R5 ready ignored while empty", pend_count, 0);
    wait_rise(n);
    check(n == BASE/2, "R9 restart from zero on exit", n, BASE/2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full();
    t_scaled(2'b01, BASE/2, "R3 half interval");
    t_scaled(2'b10, BASE/4, "R3 quarter interval");
    t_scaled(2'b11, BASE/4, "R3 code 11 as quarter");
    t_change();
    t_backpressure();
    t_saturate();
    t_emergency();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule